// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is the device end of a small three-wire serial nonvolatile memory, built as synthesizable logic with a register array as the backing store. A host selects the device with `cs`, clocks bits in on `sk_in` and `di` and receives read data or program status on `do_data`. `do_oe` is the enable for the data-out pad; when it is low the line is high impedance. All three inputs are oversampled in the `clk` domain through two-flop synchronizers. Each phase of `sk_in`, high and low, must last at least three `clk` periods.

A host frame is a 1 start bit, a 2-bit opcode and a word address. Write-type frames then carry a data word. `WORD16` selects between two organisations. With `WORD16=1` the store holds 64 words of 16 bits. With `WORD16=0` it holds 128 words of 8 bits. The commands that modify the array are write, erase, erase-all and write-all. They take effect only while the write-enable latch is set. Each one runs as a self-timed program cycle of `PROG_CYCLES` system clocks. The cycle starts when chip select falls, and no serial clock is needed while it runs. During the cycle a selected device reports busy or ready on data-out.

Top module: `mw_eeprom_slave`

## Requirements
- R1: A frame begins at the first `di`=1 sampled while selected, which is the start bit; zeros before it are ignored. The start bit is followed by a 2-bit opcode, MSB first, and then the address: 6 bits when WORD16=1, 7 bits when WORD16=0. Write and write-all frames then carry a data word of 16 bits (WORD16=1) or 8 bits (WORD16=0), MSB first.
- R2: Input bits are taken from `di` on rising edges of `sk_in` only while `cs` is high.
- R3: Opcode 10 reads. After the last address bit, data-out is enabled and shows a single 0. Each later `sk_in` rising edge presents the next bit of the addressed word, MSB first. The rising edge after the LSB returns data-out to high impedance until the device is deselected.
- R4: Opcode 00 takes its sub-command from the top two address bits: 11 sets the write-enable latch, 00 clears it, 10 erases all words and 01 writes all words. The remaining address bits are ignored. The latch is clear after reset.
- R5: Opcode 01 stores the data word at the address, replacing whatever was there; no prior erase is needed.
- R6: Opcode 11 sets the addressed word to all ones.
- R7: Erase-all sets every word to all ones. Write-all stores its data word in every location.
- R8: While the write-enable latch is clear, write, erase, erase-all and write-all change nothing and start no program cycle. Reads work whatever the latch state.
- R9: A fully received modifying command starts its program cycle on the falling edge of `cs`. The cycle lasts PROG_CYCLES system clocks, after which the array is updated. If `cs` falls before a frame is complete, the partial frame is discarded and no cycle starts.
- R10: Once a program cycle has started, a selected device drives data-out low while busy and high when ready.
- R11: A `di`=1 sampled on an `sk_in` rising edge while status is shown returns data-out to high impedance. That bit is consumed and is not a start bit.
- R12: Data-out is high impedance whenever `cs` is low. Frames sent during a program cycle are ignored.
- R13: After reset every word reads as all ones and data-out is high impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk_in | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| do_data | output | 1 | Serial data out value |
| do_oe | output | 1 | Data-out enable; 0 means high impedance |

## Verification
Several properties are checked on every cycle:
- a program cycle begins only with the latch set and the device deselected;
- its counter falls by one each clock;
- the decoder stays idle while a cycle runs;
- a read always opens with the dummy 0;
- status and read data never drive the line together.

Other behaviour only the bench scenarios can show:
- the words actually stored by write, erase, erase-all and write-all;
- how the read bit stream is ordered;
- that commands are dropped when the latch is clear, during a cycle, or when a frame is cut short;
- that a dummy 1 releases data-out.

For these the bench sends complete frames and compares each read word against a behavioural model of the array.

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
  parameter bit WORD16      = 1'b1,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk_in,
  input  logic di,
  output logic do_data,
  output logic do_oe
);
  localparam int DW    = WORD16 ? 16 : 8;
  localparam int AW    = WORD16 ? 6 : 7;
  localparam int HW    = 2 + AW;
  localparam int SW    = (HW > DW) ? HW : DW;
  localparam int CW    = $clog2(SW + 1);
  localparam int BW    = $clog2(PROG_CYCLES + 1);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_READ, S_DONE} state_t;
  typedef enum logic [1:0] {K_WRITE, K_ERASE, K_ERAL, K_WRAL} kind_t;

  logic [1:0] cs_p, sk_p, di_p;
  logic       cs_q, sk_q;
  logic       cs_s, di_s, rise, cs_fall;

  state_t          state;
  kind_t           kind;
  logic [CW-1:0]   cnt;
  logic [SW-2:0]   sr;
  logic [SW-1:0]   nsr;
  logic [AW-1:0]   addr;
  logic [DW-1:0]   wdata, rd_sr;
  logic [CW-1:0]   rd_left;
  logic            rd_oe, rd_bit, wen, pend, busy, stat_on;
  logic [BW-1:0]   bcnt;
  logic [DW-1:0]   mem [DEPTH];

  logic [1:0]      hop, hsub;
  logic [AW-1:0]   haddr;

  assign cs_s    = cs_p[1];
  assign di_s    = di_p[1];
  assign rise    = sk_p[1] & ~sk_q & cs_s;
  assign cs_fall = cs_q & ~cs_s;
  assign nsr     = {sr, di_s};
  assign hop     = nsr[HW-1:HW-2];
  assign haddr   = nsr[AW-1:0];
  assign hsub    = nsr[AW-1:AW-2];

  assign do_oe   = cs & cs_s & (rd_oe | stat_on);
  assign do_data = stat_on ? ~busy : rd_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '0; sk_p <= '0; di_p <= '0;
      cs_q <= 1'b0; sk_q <= 1'b0;
    end else begin
      cs_p <= {cs_p[0], cs};
      sk_p <= {sk_p[0], sk_in};
      di_p <= {di_p[0], di};
      cs_q <= cs_p[1];
      sk_q <= sk_p[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; kind <= K_WRITE; cnt <= '0; sr <= '0;
      addr <= '0; wdata <= '0; rd_sr <= '0; rd_left <= '0;
      rd_oe <= 1'b0; rd_bit <= 1'b0; wen <= 1'b0; pend <= 1'b0;
      busy <= 1'b0; stat_on <= 1'b0; bcnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      if (busy) begin
        if (bcnt == '0) begin
          busy <= 1'b0;
          case (kind)
            K_WRITE: mem[addr] <= wdata;
            K_ERASE: mem[addr] <= '1;
            K_ERAL:  for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
            K_WRAL:  for (int i = 0; i < DEPTH; i++) mem[i] <= wdata;
          endcase
        end else begin
          bcnt <= bcnt - 1'b1;
        end
      end

      if (!cs_s) begin
        state <= S_IDLE; cnt <= '0; rd_oe <= 1'b0; pend <= 1'b0;
        if (cs_fall && pend && wen && !busy) begin
          busy    <= 1'b1;
          bcnt    <= BW'(PROG_CYCLES - 1);
          stat_on <= 1'b1;
        end
      end else if (rise) begin
        if (stat_on && di_s) begin
          stat_on <= 1'b0;
        end else if (!busy) begin
          case (state)
            S_IDLE: if (di_s) begin state <= S_HDR; cnt <= '0; end
            S_HDR: begin
              sr  <= nsr[SW-2:0];
              cnt <= cnt + 1'b1;
              if (cnt == CW'(HW - 1)) begin
                addr <= haddr;
                cnt  <= '0;
                case (hop)
                  2'b10: begin
                    rd_sr <= mem[haddr]; rd_left <= CW'(DW);
                    rd_oe <= 1'b1; rd_bit <= 1'b0; state <= S_READ;
                  end
                  2'b01: begin kind <= K_WRITE; state <= S_DATA; end
                  2'b11: begin kind <= K_ERASE; pend <= 1'b1; state <= S_DONE; end
                  default: begin
                    state <= S_DONE;
                    case (hsub)
                      2'b11: wen <= 1'b1;
                      2'b00: wen <= 1'b0;
                      2'b10: begin kind <= K_ERAL; pend <= 1'b1; end
                      default: begin kind <= K_WRAL; state <= S_DATA; end
                    endcase
                  end
                endcase
              end
            end
            S_DATA: begin
              sr  <= nsr[SW-2:0];
              cnt <= cnt + 1'b1;
              if (cnt == CW'(DW - 1)) begin
                wdata <= nsr[DW-1:0]; pend <= 1'b1; state <= S_DONE;
              end
            end
            S_READ: begin
              if (rd_left != '0) begin
                rd_bit  <= rd_sr[DW-1];
                rd_sr   <= {rd_sr[DW-2:0], 1'b0};
                rd_left <= rd_left - 1'b1;
              end else begin
                rd_oe <= 1'b0; state <= S_DONE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  p_wen_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wen);
  p_start_deselected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !cs_s);
  p_busy_countdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> bcnt == $past(bcnt) - 1'b1);
  p_ignore_while_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> state == S_IDLE);
  p_read_dummy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_oe) |-> !rd_bit);
  p_status_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_oe && stat_on));
endmodule

// File: tb/mw_eeprom_slave_bench.sv
module mw_eeprom_slave_bench;
  localparam int PROG = 1000;
  localparam int DW   = 16;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk_in = 1'b0, di = 1'b0;
  logic do_data, do_oe;
  int   checks = 0, fails = 0;
  logic [15:0] model [64];
  bit   model_wen = 0;

  always #4 clk = ~clk;

  mw_eeprom_slave #(.WORD16(1'b1), .PROG_CYCLES(PROG)) u_mw_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk_in(sk_in), .di(di),
    .do_data(do_data), .do_oe(do_oe));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sbit(input logic b);
    @(negedge clk); sk_in = 1'b0; di = b;
    repeat (8) @(negedge clk);
    sk_in = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic sel();
    @(negedge clk); sk_in = 1'b0; cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk); sk_in = 1'b0; cs = 1'b0; di = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic shdr(input logic [1:0] op, input logic [5:0] a);
    sbit(1'b1); sbit(op[1]); sbit(op[0]);
    for (int i = 5; i >= 0; i--) sbit(a[i]);
  endtask

  task automatic sdata(input logic [15:0] d, input int nbits);
    for (int i = 15; i > 15 - nbits; i--) sbit(d[i]);
  endtask

  task automatic read_word(input logic [5:0] a, input string tag);
    logic [15:0] w;
    sel();
    shdr(2'b10, a);
    chk({tag, " R3 dummy enable"}, do_oe, 1'b1);
    chk({tag, " R3 dummy zero"}, do_data, 1'b0);
    for (int i = 0; i < DW; i++) begin
      sbit(1'b0);
      w = {w[14:0], do_data};
    end
    chk(tag, w, model[a]);
    sbit(1'b0);
    chk({tag, " R3 release after LSB"}, do_oe, 1'b0);
    desel();
  endtask

  task automatic release_status(input string tag);
    sel();
    chk({tag, " R10 ready enable"}, do_oe, 1'b1);
    chk({tag, " R10 ready level"}, do_data, 1'b1);
    sbit(1'b1);
    chk({tag, " R11 dummy one release"}, do_oe, 1'b0);
    desel();
  endtask

  task automatic modify(input logic [1:0] op, input logic [5:0] a,
                        input logic [15:0] d, input bit has_data, input string tag);
    sel();
    shdr(op, a);
    if (has_data) sdata(d, 16);
    desel();
    repeat (PROG + 20) @(negedge clk);
    if (model_wen) begin
      if (op == 2'b01) model[a] = d;
      else if (op == 2'b11) model[a] = 16'hFFFF;
      else if (a[5:4] == 2'b10) for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
      else if (a[5:4] == 2'b01) for (int i = 0; i < 64; i++) model[i] = d;
      release_status(tag);
    end else begin
      sel();
      chk({tag, " R8 no cycle started"}, do_oe, 1'b0);
      desel();
    end
  endtask

  task automatic set_wen(input bit en);
    sel();
    shdr(2'b00, en ? 6'b110101 : 6'b001010);
    desel();
    model_wen = en;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R13 reset high impedance", do_oe, 1'b0);
    read_word(6'd5, "R13 reset word all ones");

    modify(2'b01, 6'd3, 16'h1111, 1, "R8 write while disabled");
    read_word(6'd3, "R8 word unchanged");

    set_wen(1);
    modify(2'b01, 6'd3, 16'hA5C3, 1, "R5 write");
    read_word(6'd3, "R5 stored word");
    modify(2'b01, 6'd3, 16'h1234, 1, "R5 overwrite");
    read_word(6'd3, "R5 overwrite without erase");
    modify(2'b11, 6'd3, 16'h0, 0, "R6 erase");
    read_word(6'd3, "R6 erased word");

    sel(); shdr(2'b01, 6'd20); sdata(16'h0F0F, 16);
    @(negedge clk); cs = 1'b0; repeat (4) @(negedge clk);
    cs = 1'b1; repeat (6) @(negedge clk);
    chk("R10 busy enable", do_oe, 1'b1);
    chk("R10 busy low", do_data, 1'b0);
    repeat (480) @(negedge clk);
    chk("R9 still busy mid cycle", do_data, 1'b0);
    repeat (600) @(negedge clk);
    chk("R9 ready after cycle", do_data, 1'b1);
    sbit(1'b1);
    chk("R11 release after ready", do_oe, 1'b0);
    desel();
    model[20] = 16'h0F0F;
    read_word(6'd20, "R9 self-timed write");

    sel(); shdr(2'b01, 6'd7); sdata(16'hBEEF, 16);
    @(negedge clk); cs = 1'b0; repeat (4) @(negedge clk);
    cs = 1'b1; repeat (4) @(negedge clk);
    sbit(1'b1);
    shdr(2'b01, 6'd8); sdata(16'h0000, 16);
    desel();
    repeat (PROG + 20) @(negedge clk);
    model[7] = 16'hBEEF;
    read_word(6'd8, "R12 frame during cycle ignored");
    read_word(6'd7, "R12 cycle write kept");

    sel(); shdr(2'b01, 6'd9); sdata(16'h0000, 8); desel();
    repeat (PROG + 20) @(negedge clk);
    sel(); chk("R9 partial frame starts no cycle", do_oe, 1'b0); desel();
    read_word(6'd9, "R9 partial frame discarded");

    sel(); sbit(1'b0); sbit(1'b0); shdr(2'b10, 6'd7);
    chk("R1 leading zeros then read", do_oe, 1'b1);
    desel();
    chk("R12 deselect high impedance", do_oe, 1'b0);

    modify(2'b00, 6'b011111, 16'h5A5A, 1, "R7 write all");
    read_word(6'd0, "R7 write all word 0");
    read_word(6'd63, "R7 write all word 63");
    modify(2'b00, 6'b100011, 16'h0, 0, "R7 erase all");
    read_word(6'd10, "R7 erase all word 10");

    modify(2'b01, 6'd1, 16'h7777, 1, "R4 write enable again");
    set_wen(0);
    modify(2'b01, 6'd1, 16'h0000, 1, "R4 write after disable");
    read_word(6'd1, "R4 disabled write ignored R2");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule